// File: doc/BRIEF.md
# Dual PWM Delta-Sigma Dimmer

The block dims two LED strings from two 15-bit brightness levels. A single triangular counter, shared by both channels, runs from 0 up to 255 and back down to 0. Each channel drives its pin high while the counter is below that channel's active compare value. The upper eight bits of a level give the coarse duty. The lower seven bits are spread over successive counter periods by a first-order error accumulator: in some periods the compare value is one count higher. Averaged over many periods, the duty then has 15-bit resolution.

The controller writes both levels together through a one-cycle load strobe. A loaded level reaches the output in the very next cycle, without waiting for a period boundary, so short flashes and strobe effects track the command exactly. A separate one-cycle zero strobe turns both strings fully off. Choosing levels, ramping them and reacting to temperature are done upstream of this block.

Top module: `dual_dsm_dimmer`

## Requirements
- R1: A level word is 15 bits wide. Bits [14:7] are the coarse base and bits [6:0] are the dither fraction.
- R2: One counter serves both channels. After reset it holds 0 and counts up by one each cycle to 255, then down by one to 0, then up again. A full period is 510 cycles, and the cycle in which the counter holds 0 is the period boundary.
- R3: A channel pin is high exactly when the counter value is below that channel's active compare value. An active value of 0 keeps the pin low for the whole period.
- R4: On each boundary cycle without a strobe, a channel's active value takes its pending value. The 7-bit fraction is added to the channel's 7-bit accumulator. The pending value becomes base+1 if the sum exceeds 127 and base otherwise. The accumulator keeps the sum modulo 128.
- R5: Apart from boundaries, loads and zero strobes, the active compare value never changes.
- R6: A load stores both input levels and sets both the active and the pending value of each channel to its base, effective from the next cycle. This happens even when the load falls on a boundary cycle. A load leaves the accumulators unchanged.
- R7: A zero strobe clears both stored levels and both active and pending values, so both pins are low from the next cycle. When load and zero arrive together, zero wins.
- R8: A base of 255 with a carry gives a compare value of 256, which holds the pin high for all 510 cycles of that period.
- R9: Reset clears counter, levels, compare values and accumulators. Both pins then stay low until a level is loaded.
- R10: On every boundary the accumulator advances using the fraction stored before that edge, including when a load or zero strobe arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-cycle strobe that takes both level inputs |
| zero_i | input | 1 | One-cycle strobe that turns both channels off; has priority over load |
| level_a_i | input | 15 | Level for channel A: base in [14:7], fraction in [6:0] |
| level_b_i | input | 15 | Level for channel B: base in [14:7], fraction in [6:0] |
| pwm_a_o | output | 1 | Channel A PWM pin |
| pwm_b_o | output | 1 | Channel B PWM pin |

## Verification
The properties assume that both strobes and both level inputs hold known values at every sampled edge. They also assume that the level inputs matter only in the cycle in which load is high. The load property reads the levels from that same cycle. The bench therefore changes inputs only on the falling clock edge and keeps each strobe high for one cycle. The only overlap it drives is a deliberate one: load and zero together, and a load placed exactly on a boundary cycle, so that the priority rules are exercised.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  localparam int unsigned DEF_CNT_W  = 8;
  localparam int unsigned DEF_FRAC_W = 7;
  localparam int unsigned NCH        = 2;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/dsd_tri_counter.sv
module dsd_tri_counter
  import dsd_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);
  localparam logic [CNT_W-1:0] TOP  = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  cnt_dir_e         dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      dir_q <= DIR_UP;
    end else if (cnt_q == ZERO) begin
      cnt_q <= ONE;
      dir_q <= DIR_UP;
    end else if (cnt_q == TOP) begin
      cnt_q <= TOP - ONE;
      dir_q <= DIR_DOWN;
    end else if (dir_q == DIR_UP) begin
      cnt_q <= cnt_q + ONE;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = (cnt_q == ZERO);
endmodule

// File: rtl/dsd_dither_chan.sv
module dsd_dither_chan #(
  parameter int unsigned CNT_W  = dsd_pkg::DEF_CNT_W,
  parameter int unsigned FRAC_W = dsd_pkg::DEF_FRAC_W,
  localparam int unsigned LVL_W = CNT_W + FRAC_W,
  localparam int unsigned CMP_W = CNT_W + 1,
  localparam int unsigned SUM_W = FRAC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             zero_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [CMP_W-1:0] live_o,
  output logic [CMP_W-1:0] pend_o
);
  function automatic logic [SUM_W-1:0] acc_sum(logic [FRAC_W-1:0] acc,
                                               logic [FRAC_W-1:0] frac);
    return {1'b0, acc} + {1'b0, frac};
  endfunction

  function automatic logic [CMP_W-1:0] cmp_from(logic [CNT_W-1:0] base,
                                                logic carry);
    return {1'b0, base} + {{CNT_W{1'b0}}, carry};
  endfunction

  logic [LVL_W-1:0]  level_q;
  logic [FRAC_W-1:0] acc_q;
  logic [CMP_W-1:0]  live_q;
  logic [CMP_W-1:0]  pend_q;
  logic [SUM_W-1:0]  sum_w;
  logic              carry_w;

  assign sum_w   = acc_sum(acc_q, level_q[FRAC_W-1:0]);
  assign carry_w = sum_w[FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      acc_q   <= '0;
      live_q  <= '0;
      pend_q  <= '0;
    end else begin
      if (tick_i) acc_q <= sum_w[FRAC_W-1:0];
      if (zero_i) begin
        level_q <= '0;
        live_q  <= '0;
        pend_q  <= '0;
      end else if (load_i) begin
        level_q <= level_i;
        live_q  <= cmp_from(level_i[LVL_W-1:FRAC_W], 1'b0);
        pend_q  <= cmp_from(level_i[LVL_W-1:FRAC_W], 1'b0);
      end else if (tick_i) begin
        live_q  <= pend_q;
        pend_q  <= cmp_from(level_q[LVL_W-1:FRAC_W], carry_w);
      end
    end
  end

  assign live_o = live_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/dsd_pwm_cmp.sv
module dsd_pwm_cmp #(
  parameter int unsigned CNT_W = dsd_pkg::DEF_CNT_W,
  localparam int unsigned CMP_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CMP_W-1:0] cmp_i,
  output logic             pwm_o
);
  always_comb pwm_o = ({1'b0, cnt_i} < cmp_i);
endmodule

// File: rtl/dual_dsm_dimmer.sv
module dual_dsm_dimmer #(
  parameter int unsigned CNT_W  = dsd_pkg::DEF_CNT_W,
  parameter int unsigned FRAC_W = dsd_pkg::DEF_FRAC_W,
  localparam int unsigned LVL_W = CNT_W + FRAC_W,
  localparam int unsigned CMP_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             zero_i,
  input  logic [LVL_W-1:0] level_a_i,
  input  logic [LVL_W-1:0] level_b_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o
);
  localparam int unsigned NCH = dsd_pkg::NCH;

  logic [CNT_W-1:0]            cnt_q;
  logic                        period_tick;
  logic [NCH-1:0][LVL_W-1:0]   level_in;
  logic [NCH-1:0][CMP_W-1:0]   live_cmp;
  logic [NCH-1:0][CMP_W-1:0]   pend_cmp;
  logic [NCH-1:0]              pwm_w;

  assign level_in[0] = level_a_i;
  assign level_in[1] = level_b_i;

  dsd_tri_counter #(.CNT_W(CNT_W)) ctr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_o  (cnt_q),
    .tick_o (period_tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dsd_dither_chan #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) dith_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (period_tick),
      .load_i  (load_i),
      .zero_i  (zero_i),
      .level_i (level_in[g]),
      .live_o  (live_cmp[g]),
      .pend_o  (pend_cmp[g])
    );

    dsd_pwm_cmp #(.CNT_W(CNT_W)) cmp_i (
      .cnt_i (cnt_q),
      .cmp_i (live_cmp[g]),
      .pwm_o (pwm_w[g])
    );
  end

  assign pwm_a_o = pwm_w[0];
  assign pwm_b_o = pwm_w[1];
endmodule

// File: rtl/dsd_dimmer_chk.sv
module dsd_dimmer_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned FRAC_W = 7,
  localparam int unsigned LVL_W = CNT_W + FRAC_W,
  localparam int unsigned CMP_W = CNT_W + 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  load_i,
  input logic                  zero_i,
  input logic [LVL_W-1:0]      level_a_i,
  input logic [LVL_W-1:0]      level_b_i,
  input logic                  pwm_a_o,
  input logic                  pwm_b_o,
  input logic [CNT_W-1:0]      cnt_q,
  input logic                  period_tick,
  input logic [1:0][CMP_W-1:0] live_cmp,
  input logic [1:0][CMP_W-1:0] pend_cmp
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CMP_W-1:0] FULL  = CMP_W'(1) << CNT_W;

  // R2: leaving the bottom always goes to 1
  a_r2_leave_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |=> (cnt_q == ONE));

  // R2: elsewhere the counter moves by exactly one step
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !period_tick |=> ((cnt_q == $past(cnt_q) + ONE) || ($past(cnt_q) == cnt_q + ONE)));

  // R4: boundary without strobe promotes the pending value
  a_r4_take_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (period_tick && !load_i && !zero_i) |=> (live_cmp == $past(pend_cmp)));

  // R5: no change without a cause
  a_r5_hold_live: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_tick && !load_i && !zero_i) |=> $stable(live_cmp));

  // R6: load reaches active value next cycle
  a_r6_load_now: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !zero_i) |=>
      ((live_cmp[0] == {1'b0, $past(level_a_i[LVL_W-1:FRAC_W])}) &&
       (live_cmp[1] == {1'b0, $past(level_b_i[LVL_W-1:FRAC_W])}) &&
       (pend_cmp == live_cmp)));

  // R7: zero darkens both pins next cycle
  a_r7_zero_dark: assert property (@(posedge clk) disable iff (!rst_n)
    zero_i |=> (!pwm_a_o && !pwm_b_o && (live_cmp == '0)));

  // R3: active value 0 keeps the pin low
  a_r3_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cmp[0] == '0) |-> !pwm_a_o);

  // R8: saturated value keeps the pin high
  a_r8_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cmp[1] == FULL) |-> pwm_b_o);
endmodule

bind dual_dsm_dimmer dsd_dimmer_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .zero_i      (zero_i),
  .level_a_i   (level_a_i),
  .level_b_i   (level_b_i),
  .pwm_a_o     (pwm_a_o),
  .pwm_b_o     (pwm_b_o),
  .cnt_q       (cnt_q),
  .period_tick (period_tick),
  .live_cmp    (live_cmp),
  .pend_cmp    (pend_cmp)
);

// File: tb/dual_dsm_dimmer_tb_top.sv
module dual_dsm_dimmer_tb_top;
  localparam int PER = 510;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld = 1'b0;
  logic        zr = 1'b0;
  logic [14:0] la = '0;
  logic [14:0] lb = '0;
  logic        pwm_a, pwm_b;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  string tag = "R9 reset";

  // behavioural reference state
  int m_phase = 0;
  int m_live[2] = '{0, 0};
  int m_pend[2] = '{0, 0};
  int m_acc[2]  = '{0, 0};
  int m_lvl[2]  = '{0, 0};
  int t_sum;
  int t_in[2];

  always #5 clk = ~clk;

  dual_dsm_dimmer dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .zero_i(zr),
    .level_a_i(la), .level_b_i(lb), .pwm_a_o(pwm_a), .pwm_b_o(pwm_b)
  );

  function automatic int cnt_of(int ph);
    return (ph < 256) ? ph : (PER - ph);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0;
      for (int c = 0; c < 2; c++) begin
        m_live[c] = 0; m_pend[c] = 0; m_acc[c] = 0; m_lvl[c] = 0;
      end
    end else begin
      t_in[0] = int'(la);
      t_in[1] = int'(lb);
      for (int c = 0; c < 2; c++) begin
        if (m_phase == 0) begin
          t_sum = m_acc[c] + (m_lvl[c] % 128);
          m_live[c] = m_pend[c];
          m_pend[c] = (m_lvl[c] / 128) + ((t_sum > 127) ? 1 : 0);
          m_acc[c] = t_sum % 128;
        end
        if (zr) begin
          m_lvl[c] = 0; m_live[c] = 0; m_pend[c] = 0;
        end else if (ld) begin
          m_lvl[c] = t_in[c];
          m_live[c] = t_in[c] / 128;
          m_pend[c] = t_in[c] / 128;
        end
      end
      m_phase = (m_phase + 1) % PER;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      chk(pwm_a == (cnt_of(m_phase) < m_live[0]), {tag, " R3 pin A"},
          int'(pwm_a), int'(cnt_of(m_phase) < m_live[0]));
      chk(pwm_b == (cnt_of(m_phase) < m_live[1]), {tag, " R3 pin B"},
          int'(pwm_b), int'(cnt_of(m_phase) < m_live[1]));
    end
  end

  task automatic pulse(input bit do_ld, input bit do_zr, input int a, input int b);
    la = 15'(a); lb = 15'(b); ld = do_ld; zr = do_zr;
    @(negedge clk);
    ld = 1'b0; zr = 1'b0;
  endtask

  task automatic to_phase(input int p);
    do @(negedge clk); while (m_phase != p);
  endtask

  task automatic count_high(input int n, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_a) ha++;
      if (pwm_b) hb++;
    end
  endtask

  initial begin
    int ha, hb, gap, run, best;
    logic prev;
    repeat (20) @(negedge clk);
    chk(!pwm_a && !pwm_b, "R9 pins low in reset", int'(pwm_a | pwm_b), 0);
    rst_n = 1'b1;
    count_high(600, ha, hb);
    chk(ha == 0 && hb == 0, "R9 dark after reset", ha + hb, 0);

    // R1 R3: base 100 on A, base 30 on B, no fraction
    tag = "R1 R3 base only";
    @(negedge clk);
    pulse(1, 0, 100 << 7, 30 << 7);
    to_phase(1);
    count_high(PER, ha, hb);
    chk(ha == 199, "R1 high cycles A", ha, 199);
    chk(hb == 59, "R1 high cycles B", hb, 59);

    // R2: distance between rising edges
    tag = "R2 period";
    prev = pwm_a;
    do begin @(negedge clk); if (pwm_a && !prev) break; prev = pwm_a; end while (1);
    gap = 0; prev = pwm_a;
    do begin @(negedge clk); gap++; if (pwm_a && !prev) break; prev = pwm_a; end while (1);
    chk(gap == PER, "R2 period length", gap, PER);

    // R4 R10: fractions dither over many periods
    tag = "R4 R10 dither";
    pulse(1, 0, (10 << 7) | 64, (77 << 7) | 5);
    repeat (6 * PER) @(negedge clk);

    // R6: load mid-period takes effect next cycle
    tag = "R6 load mid-period";
    pulse(0, 1, 0, 0);
    to_phase(50);
    pulse(1, 0, 200 << 7, (3 << 7) | 127);
    chk(pwm_a == 1'b1, "R6 immediate high", int'(pwm_a), 1);
    repeat (3 * PER) @(negedge clk);

    // R6 R10: load exactly on a boundary cycle
    tag = "R6 R10 load on boundary";
    to_phase(0);
    pulse(1, 0, (40 << 7) | 100, (120 << 7) | 33);
    repeat (3 * PER) @(negedge clk);

    // R5: level inputs wiggle with no strobe
    tag = "R5 hold";
    to_phase(200);
    la = 15'h7fff; lb = 15'h0001;
    repeat (2 * PER) @(negedge clk);

    // R7: zero and load together, zero wins
    tag = "R7 zero priority";
    pulse(1, 1, 250 << 7, 250 << 7);
    count_high(PER, ha, hb);
    chk(ha == 0 && hb == 0, "R7 dark after zero", ha + hb, 0);

    // R8: base 255 plus carry saturates
    tag = "R8 saturate";
    pulse(1, 0, 0, (255 << 7) | 127);
    best = 0; run = 0;
    for (int i = 0; i < 8 * PER; i++) begin
      @(negedge clk);
      run = pwm_b ? run + 1 : 0;
      if (run > best) best = run;
    end
    chk(best >= PER, "R8 full period high", best, PER);

    tag = "R7 final zero";
    pulse(0, 1, 0, 0);
    count_high(PER, ha, hb);
    chk(ha == 0 && hb == 0, "R7 dark at end", ha + hb, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    while (cycles < 150000 && !done) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule